// File: doc/BRIEF.md
# Configurable SPI Master Controller

A synchronous serial master that runs one full-duplex word exchange at a time with a single selected slave. A host pulses `start_i` with a transmit word, a word length, a slave index, a polarity/phase mode, a clock divider and a select-to-clock wait. The block asserts one active-low select line, toggles the serial clock for exactly two edges per bit, and shifts the word out most significant bit first. Each bit received on the input line enters at the low end of the same ring register. When the last bit is in, the block pulses `done_o` for one system clock, and the received word is valid on `rx_word_o` in that same cycle.

The serial clock runs at the system clock divided by a programmable half-period. Word lengths run from 1 bit up to the full data width, so lengths that are not multiples of eight are allowed. With `hold_i` high, the select line stays low after a word completes, so the next start continues the same frame without a new setup wait.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset all select lines are high, `sclk_o` is 0, and `busy_o`, `done_o` and `rx_word_o` are all 0.
- R2: The mode number carries clock polarity in `mode_i[1]` and phase in `mode_i[0]`. `sclk_o` rests at the polarity level. When a select line falls, `sclk_o` already equals the polarity level and did not change on that clock. `sclk_o` never toggles while no slave is selected, except for one settling change before a new frame.
- R3: With phase 0, `miso_i` is sampled on the leading (first) edge of each bit and `mosi_o` changes on the trailing edge. With phase 1, `mosi_o` changes on the leading edge and `miso_i` is sampled on the trailing edge.
- R4: For a length L, bits `tx_word_i[L-1:0]` go out starting with bit L-1. The received bits fill `rx_word_o[L-1:0]`, with the first bit received at position L-1, and the upper bits are 0. A length of 0, or a length above the data width, means the full data width.
- R5: Each word produces exactly 2L toggles of `sclk_o`, spaced `div_i`+1 system clocks apart.
- R6: In a new frame, the first serial clock edge comes `setup_i`+`div_i`+1 system clocks after the select line falls. With phase 0, `mosi_o` carries the first bit from the moment the select line falls.
- R7: Only the select line indexed by `cs_idx_i` goes low, and at most one line is ever low.
- R8: `done_o` is a single-cycle pulse that comes `div_i`+1 system clocks after the last serial edge, together with the new `rx_word_o`. `busy_o` is low from that cycle on.
- R9: With `hold_i` low at completion, the select line goes high in the cycle `done_o` is high.
- R10: With `hold_i` high at completion, the select line stays low. The next start takes effect on the next clock, and its first serial edge follows `div_i`+1 clocks after that. The new start keeps the frame's slave index and mode, whatever `cs_idx_i` and `mode_i` then carry. Dropping `hold_i` while idle raises the select line on the next clock.
- R11: A start request while `busy_o` is high is ignored. The word in flight, its length, its edge count and its single `done_o` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a word exchange (accepted only when idle) |
| tx_word_i | input | DATA_W | Word to transmit, right-justified |
| len_i | input | LEN_W | Word length in bits; 0 or above DATA_W means DATA_W |
| cs_idx_i | input | CS_IDX_W | Index of the slave to select |
| mode_i | input | 2 | Bit 1 clock polarity, bit 0 clock phase |
| div_i | input | DIV_W | Serial half-period minus one, in system clocks |
| setup_i | input | WAIT_W | Extra system clocks between select and first edge |
| hold_i | input | 1 | Keep the select line low after completion |
| miso_i | input | 1 | Serial data from slave |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rx_word_o | output | DATA_W | Received word, right-justified |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to slave |
| cs_n_o | output | NUM_CS | Active-low slave selects |

## Verification
The in-line properties check, on every cycle, that at most one select line is low, that a select line only falls onto a settled clock at the polarity level, and that the clock never moves with no slave selected except while a new frame settles. They also check that the edge count stays within twice the length, that completion is a one-cycle pulse, and that a start while busy leaves the latched configuration alone. The bench alone can show that bits cross in the right order and on the right edge for each mode. It measures the exact spacing of half-periods, the setup delay and the completion delay in system clocks, and it shows that held frames keep their slave and mode across words. It does this with a behavioural slave and a sweep over every mode, every length and two dividers.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PREP  = 2'd1,
        ST_SETUP = 2'd2,
        ST_RUN   = 2'd3
    } xfer_state_e;

    // Mode number: polarity in the high bit, phase in the low bit.
    function automatic logic mode_pol(input logic [1:0] mode);
        return mode[1];
    endfunction

    function automatic logic mode_pha(input logic [1:0] mode);
        return mode[0];
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = load_val_i;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign zero_o = (tmr_q.cnt == '0);

    // Once expired and not reloaded, the timer stays expired.
    AST_TMR_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o); // R5

endmodule

// File: rtl/spi_ring_shifter.sv
module spi_ring_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_val_i,
    input  logic              sample_i,
    input  logic              shift_i,
    input  logic              serial_i,
    output logic              msb_o,
    output logic [WORD_W-1:0] word_next_o
);

    typedef struct packed {
        logic [WORD_W-1:0] ring;
        logic              held;
        logic              pend;
    } ring_t;

    ring_t ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        if (load_i) begin
            ring_d.ring = load_val_i;
            ring_d.pend = 1'b0;
        end else begin
            if (sample_i) begin
                ring_d.held = serial_i;
                ring_d.pend = 1'b1;
            end
            if (shift_i && ring_q.pend) begin
                ring_d.ring = {ring_q.ring[WORD_W-2:0], ring_q.held};
                ring_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign msb_o       = ring_q.ring[WORD_W-1];
    assign word_next_o = ring_d.ring;

    // A bit is captured and the ring advanced on different serial edges.
    AST_SAMPLE_SHIFT_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_i && shift_i)); // R3

    // Two captures never occur without a shift between them.
    AST_NO_LOST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !load_i) |=> (!sample_i || !ring_q.pend || shift_i)); // R3

endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
    parameter int NUM_CS = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [NUM_CS-1:0] cs_n_o
);

    typedef struct packed {
        logic [NUM_CS-1:0] lines;
    } sel_t;

    sel_t sel_d, sel_q;
    logic [NUM_CS-1:0] line_d;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_line
        assign line_d[g] = !(en_i && (idx_i == IDX_W'(g)));
    end

    always_comb begin
        sel_d       = sel_q;
        sel_d.lines = line_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '1;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign cs_n_o = sel_q.lines;

    AST_ONE_SELECT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o)); // R7

    AST_IDLE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (&cs_n_o)); // R9

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
    import spi_xfer_pkg::*;
#(
    parameter  int DATA_W   = 32,
    parameter  int NUM_CS   = 4,
    parameter  int DIV_W    = 8,
    parameter  int WAIT_W   = 8,
    localparam int LEN_W    = $clog2(DATA_W + 1),
    localparam int CS_IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [DATA_W-1:0]   tx_word_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [CS_IDX_W-1:0] cs_idx_i,
    input  logic [1:0]          mode_i,
    input  logic [DIV_W-1:0]    div_i,
    input  logic [WAIT_W-1:0]   setup_i,
    input  logic                hold_i,
    input  logic                miso_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [DATA_W-1:0]   rx_word_o,
    output logic                sclk_o,
    output logic                mosi_o,
    output logic [NUM_CS-1:0]   cs_n_o
);

    localparam int EDGE_W = LEN_W + 1;
    localparam int TMR_W  = ((DIV_W > WAIT_W) ? DIV_W : WAIT_W) + 1;

    typedef struct packed {
        xfer_state_e         st;
        logic                sclk;
        logic [EDGE_W-1:0]   edges;
        logic [LEN_W-1:0]    len;
        logic                cpol;
        logic                cpha;
        logic [DIV_W-1:0]    div;
        logic [WAIT_W-1:0]   setup;
        logic [CS_IDX_W-1:0] cs_idx;
        logic                frame_open;
        logic                done;
        logic [DATA_W-1:0]   rx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              sh_load;
    logic [DATA_W-1:0] sh_val;
    logic              sh_sample;
    logic              sh_shift;
    logic              sh_msb;
    logic [DATA_W-1:0] sh_next;
    logic              sel_en;
    logic [LEN_W-1:0]  len_eff;
    logic              do_edge;
    logic              lead_edge;
    logic              capture_edge;

    function automatic logic [DATA_W-1:0] low_mask(input logic [LEN_W-1:0] l);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(l)) m[i] = 1'b1;
        end
        return m;
    endfunction

    assign len_eff = ((len_i == '0) || (int'(len_i) > DATA_W)) ? LEN_W'(DATA_W) : len_i;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.done   = 1'b0;
        tmr_load     = 1'b0;
        tmr_val      = '0;
        sh_load      = 1'b0;
        sh_val       = '0;
        sh_sample    = 1'b0;
        sh_shift     = 1'b0;
        do_edge      = 1'b0;
        lead_edge    = 1'b0;
        capture_edge = 1'b0;

        case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.len   = len_eff;
                    ctl_d.div   = div_i;
                    ctl_d.edges = '0;
                    sh_load     = 1'b1;
                    sh_val      = tx_word_i << (DATA_W - int'(len_eff));
                    if (ctl_q.frame_open) begin
                        // Continue a held frame: keep slave and mode, no setup wait.
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(div_i);
                        ctl_d.st = ST_SETUP;
                    end else begin
                        ctl_d.cpol   = mode_pol(mode_i);
                        ctl_d.cpha   = mode_pha(mode_i);
                        ctl_d.cs_idx = cs_idx_i;
                        ctl_d.setup  = setup_i;
                        ctl_d.sclk   = mode_pol(mode_i);
                        ctl_d.st     = ST_PREP;
                    end
                end else if (ctl_q.frame_open && !hold_i) begin
                    ctl_d.frame_open = 1'b0;
                end
            end
            ST_PREP: begin
                // Clock has settled at its rest level; select goes low now.
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(ctl_q.setup) + TMR_W'(ctl_q.div);
                ctl_d.st = ST_SETUP;
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    do_edge  = 1'b1;
                    ctl_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (tmr_zero) begin
                    if (ctl_q.edges == {ctl_q.len, 1'b0}) begin
                        sh_shift         = 1'b1;
                        ctl_d.rx         = sh_next & low_mask(ctl_q.len);
                        ctl_d.done       = 1'b1;
                        ctl_d.st         = ST_IDLE;
                        ctl_d.frame_open = hold_i;
                    end else begin
                        do_edge = 1'b1;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (do_edge) begin
            lead_edge    = ~ctl_q.edges[0];
            capture_edge = lead_edge ^ ctl_q.cpha;
            ctl_d.sclk   = ~ctl_q.sclk;
            ctl_d.edges  = ctl_q.edges + 1'b1;
            sh_sample    = capture_edge;
            sh_shift     = ~capture_edge;
            tmr_load     = 1'b1;
            tmr_val      = TMR_W'(ctl_q.div);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sel_en = (ctl_d.st == ST_SETUP) || (ctl_d.st == ST_RUN) || ctl_d.frame_open;

    spi_half_timer #(
        .CNT_W (TMR_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    spi_ring_shifter #(
        .WORD_W (DATA_W)
    ) u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (sh_load),
        .load_val_i  (sh_val),
        .sample_i    (sh_sample),
        .shift_i     (sh_shift),
        .serial_i    (miso_i),
        .msb_o       (sh_msb),
        .word_next_o (sh_next)
    );

    spi_cs_decode #(
        .NUM_CS (NUM_CS),
        .IDX_W  (CS_IDX_W)
    ) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (sel_en),
        .idx_i  (ctl_d.cs_idx),
        .cs_n_o (cs_n_o)
    );

    assign busy_o    = (ctl_q.st != ST_IDLE);
    assign done_o    = ctl_q.done;
    assign rx_word_o = ctl_q.rx;
    assign sclk_o    = ctl_q.sclk;
    assign mosi_o    = sh_msb;

    AST_SELECT_ON_SETTLED_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(cs_n_o) & ~cs_n_o)) |-> ($stable(sclk_o) && (sclk_o == ctl_q.cpol))); // R2

    AST_CLK_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        ((sclk_o != $past(sclk_o)) && (&cs_n_o)) |-> (ctl_q.st == ST_PREP)); // R2

    AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.edges <= {ctl_q.len, 1'b0}); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R8

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(ctl_q.len) && $stable(ctl_q.cs_idx) && $stable(ctl_q.cpol))); // R11

    AST_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ctl_q.frame_open) |-> (&cs_n_o)); // R9

endmodule

// File: tb/spi_xfer_master_bench.sv
`timescale 1ns/1ps
module spi_xfer_master_bench;

    localparam int W   = 16;
    localparam int NCS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [W-1:0]  tx_word_i = '0;
    logic [4:0]    len_i = '0;
    logic [1:0]    cs_idx_i = '0;
    logic [1:0]    mode_i = '0;
    logic [7:0]    div_i = '0;
    logic [7:0]    setup_i = '0;
    logic          hold_i = 1'b0;
    logic          miso = 1'b0;
    logic          busy_o, done_o, sclk_o, mosi_o;
    logic [W-1:0]  rx_word_o;
    logic [NCS-1:0] cs_n_o;

    always #2.5 clk = ~clk;

    spi_xfer_master #(.DATA_W(W), .NUM_CS(NCS)) u_spi_xfer_master (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_word_i(tx_word_i),
        .len_i(len_i), .cs_idx_i(cs_idx_i), .mode_i(mode_i), .div_i(div_i),
        .setup_i(setup_i), .hold_i(hold_i), .miso_i(miso), .busy_o(busy_o),
        .done_o(done_o), .rx_word_o(rx_word_o), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .cs_n_o(cs_n_o)
    );

    int checks = 0;
    int fails  = 0;

    // Frame description written only by the stimulus side.
    int f_cpol = 0, f_cpha = 0, f_len = 8, f_div = 0, f_cs = 0;
    logic [W-1:0] f_stx = '0;
    int arm_id = 0;

    // Monitor and behavioural slave state, written only by the monitor.
    int cyc = 0, seen_arm = 0;
    logic p_sclk = 1'b0;
    logic [NCS-1:0] p_cs = '1;
    int edge_n = 0, first_edge = 0, last_edge = 0, cs_fall = 0;
    int done_n = 0, done_cyc = 0, start_cyc = 0;
    int bad_space = 0, bad_idle = 0, bad_cs = 0, s_idx = 0;
    logic [W-1:0] s_rx = '0;
    logic lead;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (arm_id != seen_arm) begin
            seen_arm = arm_id;
            edge_n = 0; done_n = 0; bad_space = 0; bad_idle = 0; bad_cs = 0;
            s_rx = '0; s_idx = 0;
            if (f_cpha == 0) begin
                miso = f_stx[f_len-1];
                s_idx = 1;
            end
        end
        if (start_i) start_cyc = cyc;
        if (done_o) begin
            done_n = done_n + 1;
            done_cyc = cyc;
        end
        if ((&p_cs) && !(&cs_n_o)) begin
            cs_fall = cyc;
            if (sclk_o !== f_cpol[0] || p_sclk !== sclk_o) bad_idle = bad_idle + 1;
        end
        if (!(&cs_n_o) && cs_n_o !== ~(4'b0001 << f_cs)) bad_cs = bad_cs + 1;
        if (rst_n && sclk_o !== p_sclk && !(&cs_n_o)) begin
            edge_n = edge_n + 1;
            if (edge_n == 1) first_edge = cyc;
            else if (cyc - last_edge != f_div + 1) bad_space = bad_space + 1;
            last_edge = cyc;
            lead = (sclk_o != f_cpol[0]);
            if (lead ^ f_cpha[0]) begin
                s_rx = {s_rx[W-2:0], mosi_o};
            end else if (s_idx < f_len) begin
                miso = f_stx[f_len-1-s_idx];
                s_idx = s_idx + 1;
            end
        end
        p_sclk = sclk_o;
        p_cs = cs_n_o;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mask_of(input int l);
        return (l >= W) ? '1 : W'((32'd1 << l) - 1);
    endfunction

    // One word exchange. fresh: a new frame (mode and slave taken from mdrv/csdrv).
    task automatic run(input logic [1:0] mdrv, input int len_drv, input int exp_len,
                       input int dv, input int su, input int csdrv,
                       input logic [W-1:0] tx, input logic [W-1:0] stx,
                       input logic hold, input bit fresh, input int poke);
        logic [W-1:0] m;
        int k;
        m = mask_of(exp_len);
        @(posedge clk); #1;
        if (fresh) begin
            f_cpol = int'(mdrv[1]);
            f_cpha = int'(mdrv[0]);
            f_cs   = csdrv;
        end
        f_len = exp_len; f_div = dv; f_stx = stx;
        arm_id = arm_id + 1;
        @(posedge clk); #1;
        mode_i = mdrv; len_i = 5'(len_drv); div_i = 8'(dv); setup_i = 8'(su);
        cs_idx_i = 2'(csdrv); tx_word_i = tx; hold_i = hold; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        k = 0;
        while (done_n == 0 && k < 20000) begin
            if (k == poke) begin
                start_i = 1'b1; tx_word_i = ~tx; len_i = 5'd3; mode_i = ~mdrv;
                cs_idx_i = 2'(csdrv + 1);
            end
            if (k == poke + 1) start_i = 1'b0;
            @(posedge clk); #1;
            k = k + 1;
        end
        start_i = 1'b0;
        chk(rx_word_o == (stx & m), "R4 received word", rx_word_o, stx & m);
        chk((s_rx & m) == (tx & m), "R3 slave captured word", s_rx & m, tx & m);
        chk(edge_n == 2 * exp_len, "R5 edge count", edge_n, 2 * exp_len);
        chk(bad_space == 0, "R5 half-period spacing", bad_space, 0);
        if (fresh)
            chk(first_edge - cs_fall == su + dv + 1, "R6 select-to-clock wait",
                first_edge - cs_fall, su + dv + 1);
        else
            chk(first_edge - start_cyc == dv + 2, "R10 held-frame first edge",
                first_edge - start_cyc, dv + 2);
        chk(done_cyc - last_edge == dv + 1, "R8 done delay", done_cyc - last_edge, dv + 1);
        chk(done_n == 1, "R8 single done pulse", done_n, 1);
        chk(!busy_o, "R8 busy low after done", busy_o, 0);
        if (hold)
            chk(cs_n_o == ~(4'b0001 << f_cs), "R10 select kept", cs_n_o, ~(4'b0001 << f_cs));
        else
            chk(&cs_n_o, "R9 select released", cs_n_o, 4'hF);
        chk(bad_idle == 0, "R2 clock settled at select", bad_idle, 0);
        chk(bad_cs == 0, "R7 only indexed select low", bad_cs, 0);
        if (poke < 20000) begin
            repeat (10) @(posedge clk);
            #1;
            chk(done_n == 1 && edge_n == 2 * exp_len && !busy_o, "R11 late start ignored",
                done_n, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(&cs_n_o && !sclk_o, "R1 reset lines", {sclk_o, cs_n_o}, 5'h0F);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk(!busy_o && !done_o && rx_word_o == '0, "R1 reset status",
            {busy_o, done_o, rx_word_o}, 0);
        chk(&cs_n_o && !sclk_o, "R1 idle after reset", {sclk_o, cs_n_o}, 5'h0F);

        // Sweep: every mode, every length, two dividers.
        for (int m = 0; m < 4; m++) begin
            for (int l = 1; l <= W; l++) begin
                for (int d = 0; d <= 2; d += 2) begin
                    run(2'(m), l, l, d, (l * 3 + m) % 5, (l + m) % 4,
                        W'(32'h9D37 ^ (l * 177) ^ (m * 4099) ^ (d * 31)),
                        W'(32'h5AC6 + l * 113 + m * 7 + d),
                        1'b0, 1'b1, 20000);
                end
            end
        end

        // R4: length 0 and an over-range length both mean the full width.
        run(2'd1, 0, W, 1, 2, 3, 16'hC3A5, 16'h7E81, 1'b0, 1'b1, 20000);
        run(2'd2, 25, W, 0, 0, 1, 16'h1234, 16'hFEDC, 1'b0, 1'b1, 20000);

        // R5/R6: slower clock and longer setup wait.
        run(2'd3, 12, 12, 5, 9, 2, 16'h0ABC, 16'h0F0F, 1'b0, 1'b1, 20000);

        // R11: a start pulse in the middle of a word.
        run(2'd0, 10, 10, 1, 1, 0, 16'h02D5, 16'h0133, 1'b0, 1'b1, 6);

        // R10: held frame, continuation ignores new slave index and mode.
        run(2'd1, 8, 8, 1, 3, 2, 16'h00A7, 16'h005C, 1'b1, 1'b1, 20000);
        run(2'd2, 12, 12, 0, 0, 0, 16'h0F31, 16'h0A0A, 1'b1, 1'b0, 20000);
        run(2'd3, 5, 5, 2, 0, 1, 16'h0013, 16'h000E, 1'b0, 1'b0, 20000);

        // R10: dropping hold while idle releases the select on the next clock.
        run(2'd0, 7, 7, 0, 1, 3, 16'h0055, 16'h002A, 1'b1, 1'b1, 20000);
        repeat (3) @(posedge clk);
        #1;
        chk(cs_n_o == 4'b0111, "R10 select held while idle", cs_n_o, 4'b0111);
        hold_i = 1'b0;
        @(posedge clk);
        #1;
        chk(&cs_n_o, "R10 select released on hold drop", cs_n_o, 4'hF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule